// File: doc/BRIEF.md
# Serial Microwire EEPROM Word Reader with MAC Loader

This block fetches 16-bit words from a three-wire serial EEPROM that speaks the Microwire protocol. It drives chip select, serial clock and serial data toward the part and samples the part's data output. A caller places a word address on `rd_addr` and pulses `rd_req`. Some cycles later the word appears on `rd_data` together with a one-cycle `rd_done` pulse. The input `wide_sel` chooses between the smaller device size, which uses 6 address bits, and the larger one, which uses 8 address bits. The choice is made per transaction.

A loader sequencer sits on top of the reader. A pulse on `load_start` makes it read an identification word at word address 0 and compare it with 0x8129. If the word matches, it reads three further words at addresses 7, 8 and 9 and unpacks them into a 48-bit station address. It then raises `mac_valid` only when that address is a usable unicast value. Only read commands are issued. The serial clock runs at a fixed division of the system clock, set by `HALF_DIV` system cycles per half-period.

Top module: `mwire_mac_fetch`

## Requirements
- R1: A read transaction sends the opcode 3'b110 first, then the word address, each MSB first. With `wide_sel`=0 only `rd_addr[5:0]` is sent, for 9 command bits in total. With `wide_sel`=1 all of `rd_addr[7:0]` is sent, for 11 command bits. Each transaction has exactly 16 further rising clock edges for data.
- R2: `rom_cs` goes high before the first command bit and stays high until the last data bit. `rom_di` changes only while `rom_sk` is low. `rom_sk` is high only while `rom_cs` is high.
- R3: After the last command bit `rom_sk` is driven low. Sixteen data bits are then captured MSB first. Each bit is taken from `rom_do` while `rom_sk` is high, just before the clock falls. `rom_cs` then drops while `rom_sk` is low and remains low in idle.
- R4: Every high phase of `rom_sk` lasts exactly `HALF_DIV` system cycles. Every low phase inside a transaction lasts at least `HALF_DIV` cycles.
- R5: A request accepted at a clock edge makes `rd_busy` high from the next cycle until the completion cycle. In the completion cycle `rd_done` is high for one cycle and `rd_busy` is low. `rd_data` holds the word read from then until the next read completes.
- R6: `rd_req` is ignored while `rd_busy` or `load_busy` is high. `load_start` is ignored while either is high. If both arrive in the same idle cycle, the load wins and the word request is dropped.
- R7: An accepted load clears `mac_valid` and `mac_addr` and then reads word 0. If that word is not 0x8129, the load ends with a one-cycle `load_done`, `mac_valid`=0, `mac_addr`=0, and no further transaction.
- R8: After a matching identification word, words 7, 8 and 9 are read. `mac_addr[47:40]` is the low byte of word 7 and `mac_addr[39:32]` its high byte. Words 8 and 9 fill `[31:16]` and `[15:0]` the same way. `load_done` pulses when the last word has been stored.
- R9: At the end of a load, `mac_valid` is 1 only if `mac_addr[40]` (the group bit of the first byte) is 0 and `mac_addr` is not all zeros.
- R10: Reads issued by the loader use the address width chosen by `wide_sel` and never pulse `rd_done`. `load_busy` is high from the cycle after the load is accepted until the `load_done` cycle, during which it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wide_sel | input | 1 | 0: 6-bit word address, 1: 8-bit word address |
| rd_req | input | 1 | Word read request, sampled when idle |
| rd_addr | input | 8 | Word address for `rd_req` |
| rd_busy | output | 1 | A serial read is in progress |
| rd_done | output | 1 | One-cycle pulse when a requested word is ready |
| rd_data | output | 16 | Last word read |
| load_start | input | 1 | Starts the identification and address load |
| load_busy | output | 1 | Loader sequence in progress |
| load_done | output | 1 | One-cycle pulse at the end of a load |
| mac_addr | output | 48 | Assembled station address, first byte in [47:40] |
| mac_valid | output | 1 | Station address passed all checks |
| rom_cs | output | 1 | EEPROM chip select |
| rom_sk | output | 1 | EEPROM serial clock |
| rom_di | output | 1 | Serial data toward the EEPROM |
| rom_do | input | 1 | Serial data from the EEPROM |

## Verification
A bus-functional EEPROM model decodes each command by counting rising clock edges. If the design sent the wrong number of address bits, or truncated the address incorrectly in 6-bit mode (0x47 must fetch word 0x07), the returned data would land misaligned and the word would mismatch. A pin monitor watches for data changing during the clock high phase, clock activity outside chip select, chip select falling with the clock high, and clock phases of the wrong length. Each of these shows up as an off-by-one or premature edge. The loader is exercised with a wrong identification word, which must stop after one transaction, and with a group-bit address and an all-zero address, both of which a careless design would mark valid. Requests made during a busy read, and a word request colliding with a load start, must leave the pins and outputs untouched.

// File: rtl/mwire_pkg.sv
// Shared constants, state types and helpers for the serial EEPROM reader.
// Assumes a word-organised part with 16-bit words and a 3-bit read opcode.
package mwire_pkg;
    localparam int          OPCODE_W   = 3;
    localparam logic [2:0]  RD_OPCODE  = 3'b110;
    localparam int          WORD_W     = 16;
    localparam int          MAC_W      = 48;
    localparam logic [15:0] ID_WORD    = 16'h8129;
    localparam logic [7:0]  ID_ADDR    = 8'h00;
    localparam logic [7:0]  MAC_BASE   = 8'h07;

    typedef enum logic [2:0] {
        ENG_IDLE, ENG_CS_SETUP, ENG_CMD_LO, ENG_CMD_HI,
        ENG_TURN, ENG_DAT_HI, ENG_DAT_LO, ENG_CS_END
    } eng_state_t;

    typedef enum logic [2:0] {
        LD_IDLE, LD_ID, LD_W0, LD_W1, LD_W2
    } ld_state_t;

    // Swap a little-endian stored word into transmit byte order.
    function automatic logic [15:0] le_pair(input logic [15:0] w);
        return {w[7:0], w[15:8]};
    endfunction
endpackage

// File: rtl/mwire_half_tick.sv
// Half-period strobe for the serial clock.
// Emits one tick every HALF_DIV system cycles while run is high;
// the count restarts whenever run is low. Assumes HALF_DIV >= 1.
module mwire_half_tick #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    generate
        if (HALF_DIV == 1) begin : g_every
            assign tick = run;
        end else begin : g_count
            logic [CW-1:0] cnt;

            // Count system cycles within one half-period.
            always_ff @(posedge clk) begin
                if (!rst_n || !run) cnt <= '0;
                else if (tick)      cnt <= '0;
                else                cnt <= cnt + 1'b1;
            end

            assign tick = run && (cnt == CW'(HALF_DIV - 1));

            // Ticks are spaced by at least two cycles when dividing.
            p_tick_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/mwire_word_rd.sv
// Single-word Microwire read engine.
// Accepts req when idle, sends opcode and address MSB first, then shifts
// in 16 data bits while the clock is high. All pins are registered.
// Assumes the part drives a dummy zero after the address and each data
// bit after a rising clock edge.
module mwire_word_rd
    import mwire_pkg::*;
#(
    parameter int HALF_DIV  = 4,
    parameter int NARROW_AW = 6,
    parameter int WIDE_AW   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wide_sel,
    input  logic               req,
    input  logic [WIDE_AW-1:0] addr,
    output logic               busy,
    output logic               done,
    output logic [WORD_W-1:0]  data,
    output logic               cs,
    output logic               sk,
    output logic               di,
    input  logic               do_in
);
    localparam int CMD_W  = OPCODE_W + WIDE_AW;
    localparam int NCMD_W = OPCODE_W + NARROW_AW;
    localparam int PAD_W  = WIDE_AW - NARROW_AW;
    localparam int LW     = $clog2(CMD_W + 1);
    localparam int DW     = $clog2(WORD_W + 1);

    eng_state_t        state;
    logic [CMD_W-1:0]  cmd_sr;
    logic [LW-1:0]     cmd_left;
    logic [DW-1:0]     dat_cnt;
    logic [WORD_W-1:0] dat_sr;
    logic              tick;
    logic              accept;
    logic [CMD_W-1:0]  wide_cmd;
    logic [CMD_W-1:0]  narrow_cmd;

    assign busy   = (state != ENG_IDLE);
    assign accept = req && !busy;

    // Left-align the command so its first bit is always the MSB.
    assign wide_cmd   = {RD_OPCODE, addr};
    assign narrow_cmd = CMD_W'({RD_OPCODE, addr[NARROW_AW-1:0]}) << PAD_W;

    mwire_half_tick #(.HALF_DIV(HALF_DIV)) i_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .tick (tick)
    );

    // Transaction sequencer: one state step per half-period tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ENG_IDLE;
            cs       <= 1'b0;
            sk       <= 1'b0;
            di       <= 1'b0;
            cmd_sr   <= '0;
            cmd_left <= '0;
            dat_cnt  <= '0;
            dat_sr   <= '0;
            data     <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ENG_IDLE: begin
                    if (accept) begin
                        state    <= ENG_CS_SETUP;
                        cs       <= 1'b1;
                        sk       <= 1'b0;
                        di       <= 1'b0;
                        cmd_sr   <= wide_sel ? wide_cmd : narrow_cmd;
                        cmd_left <= wide_sel ? LW'(CMD_W) : LW'(NCMD_W);
                    end
                end
                ENG_CS_SETUP: begin
                    if (tick) begin
                        di    <= cmd_sr[CMD_W-1];
                        state <= ENG_CMD_LO;
                    end
                end
                ENG_CMD_LO: begin
                    if (tick) begin
                        sk    <= 1'b1;
                        state <= ENG_CMD_HI;
                    end
                end
                ENG_CMD_HI: begin
                    if (tick) begin
                        sk       <= 1'b0;
                        cmd_sr   <= cmd_sr << 1;
                        cmd_left <= cmd_left - 1'b1;
                        if (cmd_left == LW'(1)) begin
                            di    <= 1'b0;
                            state <= ENG_TURN;
                        end else begin
                            di    <= cmd_sr[CMD_W-2];
                            state <= ENG_CMD_LO;
                        end
                    end
                end
                ENG_TURN: begin
                    if (tick) begin
                        sk      <= 1'b1;
                        dat_cnt <= '0;
                        state   <= ENG_DAT_HI;
                    end
                end
                ENG_DAT_HI: begin
                    if (tick) begin
                        dat_sr  <= {dat_sr[WORD_W-2:0], do_in};
                        dat_cnt <= dat_cnt + 1'b1;
                        sk      <= 1'b0;
                        state   <= ENG_DAT_LO;
                    end
                end
                ENG_DAT_LO: begin
                    if (tick) begin
                        if (dat_cnt == DW'(WORD_W)) begin
                            cs    <= 1'b0;
                            state <= ENG_CS_END;
                        end else begin
                            sk    <= 1'b1;
                            state <= ENG_DAT_HI;
                        end
                    end
                end
                ENG_CS_END: begin
                    if (tick) begin
                        data  <= dat_sr;
                        done  <= 1'b1;
                        state <= ENG_IDLE;
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    // Data toward the part moves only in the clock low phase.
    p_di_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(di) |-> !sk);
    // Clock is active only inside chip select.
    p_sk_in_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sk |-> cs);
    // Chip select ends with the clock already low.
    p_cs_fall_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs) |-> (!sk && !$past(sk)));
    // An accepted request makes the engine busy on the next cycle.
    p_accept_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy) |=> busy);
    // Completion is a single-cycle pulse with the engine idle.
    p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/mwire_mac_seq.sv
// Station address loader.
// Reads the identification word, then three address words, through the
// word engine. Assumes the engine accepts rd_req whenever it is idle and
// that this sequencer has priority on the engine while load_busy is high.
module mwire_mac_seq
    import mwire_pkg::*;
#(
    parameter int WIDE_AW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               eng_busy,
    input  logic               eng_done,
    input  logic [WORD_W-1:0]  eng_data,
    output logic               rd_req,
    output logic [WIDE_AW-1:0] rd_addr,
    output logic               load_busy,
    output logic               load_done,
    output logic [MAC_W-1:0]   mac_addr,
    output logic               mac_valid
);
    ld_state_t        state;
    logic             waiting;
    logic             accept;
    logic [MAC_W-1:0] mac_final;

    assign load_busy = (state != LD_IDLE);
    assign accept    = start && !load_busy && !eng_busy;
    assign rd_req    = load_busy && !waiting && !eng_busy;
    assign mac_final = {mac_addr[MAC_W-1:16], le_pair(eng_data)};

    // Word address for the current step of the sequence.
    always_comb begin
        case (state)
            LD_W0:   rd_addr = WIDE_AW'(MAC_BASE);
            LD_W1:   rd_addr = WIDE_AW'(MAC_BASE + 8'd1);
            LD_W2:   rd_addr = WIDE_AW'(MAC_BASE + 8'd2);
            default: rd_addr = WIDE_AW'(ID_ADDR);
        endcase
    end

    // Step through identification check and address unpacking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= LD_IDLE;
            waiting   <= 1'b0;
            load_done <= 1'b0;
            mac_addr  <= '0;
            mac_valid <= 1'b0;
        end else begin
            load_done <= 1'b0;
            if (state == LD_IDLE) begin
                if (accept) begin
                    state     <= LD_ID;
                    waiting   <= 1'b0;
                    mac_addr  <= '0;
                    mac_valid <= 1'b0;
                end
            end else if (rd_req) begin
                waiting <= 1'b1;
            end else if (eng_done && waiting) begin
                waiting <= 1'b0;
                case (state)
                    LD_ID: begin
                        if (eng_data == ID_WORD) begin
                            state <= LD_W0;
                        end else begin
                            state     <= LD_IDLE;
                            load_done <= 1'b1;
                        end
                    end
                    LD_W0: begin
                        mac_addr[47:32] <= le_pair(eng_data);
                        state           <= LD_W1;
                    end
                    LD_W1: begin
                        mac_addr[31:16] <= le_pair(eng_data);
                        state           <= LD_W2;
                    end
                    LD_W2: begin
                        mac_addr[15:0] <= le_pair(eng_data);
                        mac_valid      <= !mac_final[40] && (|mac_final);
                        load_done      <= 1'b1;
                        state          <= LD_IDLE;
                    end
                    default: state <= LD_IDLE;
                endcase
            end
        end
    end

    // Valid can only appear together with the end-of-load pulse.
    p_valid_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mac_valid) |-> load_done);
    // The end-of-load pulse finds the loader idle.
    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> !load_busy);
    // Starting a load clears any previous result.
    p_clear_on_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!mac_valid && mac_addr == '0));
endmodule

// File: rtl/mwire_mac_fetch.sv
// Top level: Microwire word reader plus station address loader.
// The loader owns the engine while load_busy is high; outside requests
// are accepted only when both engine and loader are idle and no load is
// starting in the same cycle.
module mwire_mac_fetch
    import mwire_pkg::*;
#(
    parameter int HALF_DIV  = 4,
    parameter int NARROW_AW = 6,
    parameter int WIDE_AW   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wide_sel,
    input  logic               rd_req,
    input  logic [WIDE_AW-1:0] rd_addr,
    output logic               rd_busy,
    output logic               rd_done,
    output logic [WORD_W-1:0]  rd_data,
    input  logic               load_start,
    output logic               load_busy,
    output logic               load_done,
    output logic [MAC_W-1:0]   mac_addr,
    output logic               mac_valid,
    output logic               rom_cs,
    output logic               rom_sk,
    output logic               rom_di,
    input  logic               rom_do
);
    logic               eng_req;
    logic [WIDE_AW-1:0] eng_addr;
    logic               eng_busy;
    logic               eng_done;
    logic               seq_req;
    logic [WIDE_AW-1:0] seq_addr;

    // Engine arbitration: loader first, outside request otherwise.
    assign eng_req  = seq_req || (rd_req && !load_busy && !load_start);
    assign eng_addr = load_busy ? seq_addr : rd_addr;
    assign rd_busy  = eng_busy;
    assign rd_done  = eng_done && !load_busy;

    mwire_word_rd #(
        .HALF_DIV (HALF_DIV),
        .NARROW_AW(NARROW_AW),
        .WIDE_AW  (WIDE_AW)
    ) i_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .wide_sel(wide_sel),
        .req     (eng_req),
        .addr    (eng_addr),
        .busy    (eng_busy),
        .done    (eng_done),
        .data    (rd_data),
        .cs      (rom_cs),
        .sk      (rom_sk),
        .di      (rom_di),
        .do_in   (rom_do)
    );

    mwire_mac_seq #(.WIDE_AW(WIDE_AW)) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (load_start),
        .eng_busy (eng_busy),
        .eng_done (eng_done),
        .eng_data (rd_data),
        .rd_req   (seq_req),
        .rd_addr  (seq_addr),
        .load_busy(load_busy),
        .load_done(load_done),
        .mac_addr (mac_addr),
        .mac_valid(mac_valid)
    );

    // A started load holds the bus off from outside requests.
    p_load_blocks_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_start && !load_busy && !eng_busy) |=> (load_busy && !rd_done));
endmodule

// File: tb/test_mwire_mac_fetch.sv
module test_mwire_mac_fetch;
    localparam int HD = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_sel = 1'b1;
    logic        rd_req = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic        rd_busy, rd_done, load_busy, load_done, mac_valid;
    logic [15:0] rd_data;
    logic        load_start = 1'b0;
    logic [47:0] mac_addr;
    logic        rom_cs, rom_sk, rom_di, rom_do;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    mwire_mac_fetch #(.HALF_DIV(HD)) i_mwire_mac_fetch (
        .clk(clk), .rst_n(rst_n), .wide_sel(wide_sel),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_busy(rd_busy),
        .rd_done(rd_done), .rd_data(rd_data), .load_start(load_start),
        .load_busy(load_busy), .load_done(load_done), .mac_addr(mac_addr),
        .mac_valid(mac_valid), .rom_cs(rom_cs), .rom_sk(rom_sk),
        .rom_di(rom_di), .rom_do(rom_do)
    );

    // ---------------- EEPROM model ----------------
    logic [15:0] mem [0:255];
    int          m_edges;
    logic [10:0] m_cmd;
    logic        m_out;
    logic [15:0] m_sr;
    logic        m_do = 1'b1;
    logic [2:0]  last_op;
    logic [7:0]  last_addr;
    int          last_edges;
    int          cs_rises = 0;

    assign rom_do = m_do;

    always @(posedge rom_cs) begin
        m_edges = 0; m_cmd = '0; m_out = 1'b0; m_do = 1'b1;
        cs_rises++;
    end

    always @(negedge rom_cs) begin
        last_edges = m_edges;
        m_do = 1'b1;
    end

    always @(posedge rom_sk) begin
        if (rom_cs) begin
            m_edges++;
            if (!m_out) begin
                m_cmd = {m_cmd[9:0], rom_di};
                if (m_edges == (wide_sel ? 11 : 9)) begin
                    last_op   = wide_sel ? m_cmd[10:8] : m_cmd[8:6];
                    last_addr = wide_sel ? m_cmd[7:0] : {2'b00, m_cmd[5:0]};
                    m_sr  = mem[last_addr];
                    m_out = 1'b1;
                    m_do  = 1'b0;
                end
            end else begin
                m_do = m_sr[15];
                m_sr = {m_sr[14:0], 1'b0};
            end
        end
    end

    // ---------------- pin monitor ----------------
    logic p_sk = 0, p_di = 0, p_cs = 0;
    int hi_run = 0, lo_run = 0, sk_rises = 0;
    int v_di = 0, v_cs = 0, v_fall = 0, v_hi = 0, v_lo = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (rom_di != p_di && rom_sk) v_di++;
            if (rom_sk && !rom_cs) v_cs++;
            if (p_cs && !rom_cs && (rom_sk || p_sk)) v_fall++;
            if (rom_sk) begin
                if (!p_sk) begin
                    sk_rises++;
                    if (lo_run < HD) v_lo++;
                end
                hi_run++;
            end else begin
                if (p_sk) begin
                    if (hi_run != HD) v_hi++;
                    hi_run = 0;
                    lo_run = 0;
                end
                if (rom_cs) lo_run++;
                else lo_run = 0;
            end
        end
        p_sk = rom_sk; p_di = rom_di; p_cs = rom_cs;
    end

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_rd(output bit got);
        got = 1'b0;
        for (int i = 0; i < 4000 && !got; i++) begin
            @(negedge clk);
            if (rd_done) got = 1'b1;
        end
    endtask

    task automatic do_read(input logic [7:0] a, input bit w);
        bit got;
        logic [7:0] ea;
        ea = w ? a : (a & 8'h3F);
        wide_sel = w;
        @(negedge clk); rd_addr = a; rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0;
        chk(rd_busy === 1'b1, "R5", "busy after accept", rd_busy, 1);
        wait_rd(got);
        chk(got, "R5", "done seen", got, 1);
        chk(rd_busy === 1'b0, "R5", "busy low at done", rd_busy, 0);
        chk(rd_data === mem[ea], "R3", "word value", rd_data, mem[ea]);
        chk(last_op === 3'b110, "R1", "opcode", last_op, 3'b110);
        chk(last_addr === ea, "R1", "sent address", last_addr, ea);
        chk(last_edges == (w ? 27 : 25), "R1", "clock edges", last_edges, w ? 27 : 25);
        @(negedge clk);
        chk(rd_done === 1'b0, "R5", "done one cycle", rd_done, 0);
        chk(rd_data === mem[ea], "R5", "data held", rd_data, mem[ea]);
    endtask

    task automatic do_load(output int rdones, output int txns);
        int c0;
        bit got;
        rdones = 0; got = 1'b0;
        c0 = cs_rises;
        @(negedge clk); load_start = 1'b1;
        @(negedge clk); load_start = 1'b0;
        chk(load_busy === 1'b1, "R10", "load busy", load_busy, 1);
        chk(mac_valid === 1'b0, "R7", "valid cleared at start", mac_valid, 0);
        for (int i = 0; i < 20000 && !got; i++) begin
            @(negedge clk);
            if (rd_done) rdones++;
            if (load_done) got = 1'b1;
        end
        chk(got, "R8", "load done seen", got, 1);
        chk(load_busy === 1'b0, "R10", "idle at load done", load_busy, 0);
        txns = cs_rises - c0;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(rom_cs === 1'b0 && rom_sk === 1'b0, "R2", "pins idle", {rom_cs, rom_sk}, 0);
        chk(rd_busy === 1'b0 && rd_done === 1'b0, "R5", "reader idle", {rd_busy, rd_done}, 0);
        chk(load_busy === 1'b0 && mac_valid === 1'b0, "R7", "loader idle", {load_busy, mac_valid}, 0);
    endtask

    task automatic t_reads();
        do_read(8'h05, 1'b0);
        do_read(8'h47, 1'b0);   // R1 masking: fetches word 0x07
        do_read(8'hC3, 1'b1);
        do_read(8'h00, 1'b1);
        do_read(8'hFF, 1'b1);
    endtask

    task automatic t_pins();
        chk(sk_rises > 0, "R4", "clock active", sk_rises, 1);
        chk(v_di == 0, "R2", "di change with sk high", v_di, 0);
        chk(v_cs == 0, "R2", "sk outside cs", v_cs, 0);
        chk(v_fall == 0, "R3", "cs fall with sk high", v_fall, 0);
        chk(v_hi == 0, "R4", "high phase length", v_hi, 0);
        chk(v_lo == 0, "R4", "low phase length", v_lo, 0);
    endtask

    task automatic t_busy_ignore();
        bit got;
        int c0;
        wide_sel = 1'b1;
        c0 = cs_rises;
        @(negedge clk); rd_addr = 8'h10; rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0;
        repeat (20) @(negedge clk);
        rd_addr = 8'h20; rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0; load_start = 1'b1;
        @(negedge clk); load_start = 1'b0;
        chk(load_busy === 1'b0, "R6", "load ignored while busy", load_busy, 0);
        wait_rd(got);
        chk(rd_data === mem[8'h10], "R6", "first request kept", rd_data, mem[8'h10]);
        repeat (30) @(negedge clk);
        chk(rd_busy === 1'b0 && cs_rises - c0 == 1, "R6", "no extra transaction",
            cs_rises - c0, 1);
    endtask

    task automatic t_load_ok(input bit w);
        int rd_n, tx;
        wide_sel = w;
        mem[0] = 16'h8129;
        mem[7] = 16'h3412; mem[8] = 16'h7856; mem[9] = 16'hBC9A;
        do_load(rd_n, tx);
        chk(mac_addr === 48'h12345678_9ABC, w ? "R8" : "R10", "mac assembled",
            mac_addr, 48'h123456789ABC);
        chk(mac_valid === 1'b1, "R9", "unicast valid", mac_valid, 1);
        chk(rd_n == 0, "R10", "no rd_done in load", rd_n, 0);
        chk(tx == 4, "R8", "four transactions", tx, 4);
    endtask

    task automatic t_load_badsig();
        int rd_n, tx;
        wide_sel = 1'b1;
        mem[0] = 16'h8128;
        do_load(rd_n, tx);
        chk(mac_valid === 1'b0 && mac_addr === 48'h0, "R7", "bad id result",
            {mac_valid, mac_addr}, 0);
        chk(tx == 1, "R7", "stops after id", tx, 1);
        mem[0] = 16'h8129;
    endtask

    task automatic t_load_reject();
        int rd_n, tx;
        wide_sel = 1'b1;
        mem[7] = 16'h2201; mem[8] = 16'h4433; mem[9] = 16'h6655;
        do_load(rd_n, tx);
        chk(mac_addr === 48'h01223344_5566, "R8", "group mac assembled",
            mac_addr, 48'h012233445566);
        chk(mac_valid === 1'b0, "R9", "group bit rejected", mac_valid, 1'b0);
        mem[7] = 16'h0; mem[8] = 16'h0; mem[9] = 16'h0;
        do_load(rd_n, tx);
        chk(mac_valid === 1'b0, "R9", "zero rejected", mac_valid, 1'b0);
    endtask

    task automatic t_prio();
        int rd_n;
        bit got;
        rd_n = 0; got = 1'b0;
        wide_sel = 1'b1;
        mem[7] = 16'h3412; mem[8] = 16'h7856; mem[9] = 16'hBC9A;
        @(negedge clk); rd_addr = 8'h33; rd_req = 1'b1; load_start = 1'b1;
        @(negedge clk); rd_req = 1'b0; load_start = 1'b0;
        chk(load_busy === 1'b1, "R6", "load wins collision", load_busy, 1);
        for (int i = 0; i < 20000 && !got; i++) begin
            @(negedge clk);
            if (rd_done) rd_n++;
            if (load_done) got = 1'b1;
        end
        repeat (30) @(negedge clk);
        chk(rd_n == 0 && rd_busy === 1'b0, "R6", "word request dropped", rd_n, 0);
        chk(mac_valid === 1'b1, "R9", "valid after collision load", mac_valid, 1);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h1357) ^ 16'h2C4A;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reads();
        t_busy_ignore();
        t_load_ok(1'b1);
        t_load_ok(1'b0);
        t_load_badsig();
        t_load_reject();
        t_prio();
        t_pins();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule